// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port for a three-wire serial control bus with an active-low select line. An external host uses it to load and read back a small bank of byte-wide control registers. The registers drive analog settings elsewhere on the chip, so their contents are exposed as a flat output vector. Every access is two bytes long. The host first shifts in an instruction byte and then either a data byte to store or eight clocks during which the addressed register is shifted back out.

The host may frame an access in two ways: as one continuous low period of 16 serial clocks, or as two separate low periods of 8 clocks each. The register file sees the same result in both cases. The select line, serial clock and serial input are asynchronous to the block clock. They are brought through a synchronizer chain, and the serial clock edges are detected in the block clock domain. The serial clock therefore has to run several times slower than the block clock. A separate output-enable lets the serial output share one line with other slaves: the line is released whenever the select line is high.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset every control register reads 0 on `ctrlRegs` and `sdoOe` is low.
- R2: A write framed as one 16-clock select pulse stores the second byte into the addressed register only when the select line returns high. The register is unchanged while the select line is still low after the 16th clock.
- R3: A write framed as two 8-clock select pulses stores the same value as the single-pulse framing.
- R4: In a read, bits are sampled on the rising serial clock edge, most significant bit first. After the instruction byte, the register contents appear on `sdo`, most significant bit first, and each bit changes only after a falling serial clock edge, so the host samples bit k on rising edge 16-k.
- R5: A read framed as two 8-clock select pulses returns the same data, with the first data bit already on `sdo` when the second pulse starts.
- R6: `sdoOe` is high while the synchronized select line is low and low while it is high.
- R7: If the select line rises before 8 bits of the current byte have arrived, the partial byte is dropped and the port waits for a new instruction. A partial second byte of a write leaves every register unchanged.
- R8: Serial clocks after the 16th bit of an access are ignored: the committed value is the second byte.
- R9: A write to an address at or above `NUM_REGS` changes no register, and a read from such an address returns 0.
- R10: The instruction byte holds the register address in bits [7:2] and the direction in bit [1] (1 = read, 0 = write). Bit [0] is ignored.
- R11: A read leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo | output | 1 | Serial data out, updated after falling sclk |
| sdoOe | output | 1 | Drive enable for the shared serial output line |
| ctrlRegs | output | NUM_REGS*DATA_W | All control registers, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench builds the port with its defaults: eight registers of eight bits and a two-stage synchronizer. This places the six-bit address field well beyond the populated bank, so out-of-range writes and reads can be reached. It also keeps the whole register file visible as a single 64-bit word that can be compared in one step. The serial clock runs at one sixteenth of the block clock. That leaves room for the synchronizer latency, so the bench can sample `sdo` just before each rising edge and check register contents both before and after the select line is released.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_FULL  = 2'd2
  } phase_t;

  typedef struct packed {
    logic sdiBit;     // synchronized serial input bit
    logic shiftIn;    // take sdiBit into the input shifter
    logic instrDone;  // this shiftIn completes the instruction byte
    logic shiftOut;   // advance the read-back shifter
    logic commit;     // store the write byte into the addressed register
  } strobes_t;

endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     sclk,
  input  logic     sdi,
  input  logic     isRead,
  output strobes_t strobes,
  output logic     sdoOe,
  output logic     csSync,
  output logic     sclkFall,
  output phase_t   phase
);

  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] sclkPipe;
  logic [SYNC_STAGES-1:0] sdiPipe;
  logic                   csPrev;
  logic                   sclkPrev;
  logic                   sclkSync;
  logic                   sclkRise;
  logic                   csRise;
  logic [CNT_W-1:0]       bitCnt;
  logic                   selActive;

  // Synchronizer chains for the asynchronous serial inputs.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign csSync    = csPipe[SYNC_STAGES-1];
  assign sclkSync  = sclkPipe[SYNC_STAGES-1];
  assign sclkRise  = sclkSync & ~sclkPrev;
  assign sclkFall  = ~sclkSync & sclkPrev;
  assign csRise    = csSync & ~csPrev;
  assign selActive = ~csSync;

  // Framing state: which byte is being collected, and how far.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_INSTR;
      bitCnt <= '0;
    end else if (csRise) begin
      unique case (phase)
        PH_INSTR: bitCnt <= '0;
        PH_DATA: begin
          // A completed instruction survives a gap between two 8-clock pulses.
          if (bitCnt != '0) begin
            phase  <= PH_INSTR;
            bitCnt <= '0;
          end
        end
        default: begin
          phase  <= PH_INSTR;
          bitCnt <= '0;
        end
      endcase
    end else if (selActive && sclkRise && phase != PH_FULL) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt <= '0;
        phase  <= (phase == PH_INSTR) ? PH_DATA : PH_FULL;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sdoOe <= 1'b0;
    else       sdoOe <= selActive;
  end

  always_comb begin
    strobes.sdiBit    = sdiPipe[SYNC_STAGES-1];
    strobes.shiftIn   = selActive && sclkRise && (phase != PH_FULL);
    strobes.instrDone = strobes.shiftIn && (phase == PH_INSTR) && (bitCnt == LAST_BIT);
    strobes.shiftOut  = selActive && sclkFall && (phase == PH_DATA) && isRead;
    strobes.commit    = csRise && (phase == PH_FULL) && !isRead;
  end

endmodule

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strobes,
  output logic                       isRead,
  output logic                       sdo,
  output logic [NUM_REGS*DATA_W-1:0] ctrlRegs
);

  localparam int ADDR_W = DATA_W - 2;

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-2:0] instrReg;      // instruction bits [DATA_W-1:1]
  logic [DATA_W-1:0] readShift;
  logic [DATA_W-1:0] readVal;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic              outBit;

  assign nextAddr = shiftReg[DATA_W-2:1];  // address as the 8th bit arrives
  assign wrAddr   = instrReg[DATA_W-2:1];
  assign isRead   = instrReg[0];
  assign sdo      = outBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      instrReg <= '0;
    end else begin
      if (strobes.shiftIn)   shiftReg <= {shiftReg[DATA_W-2:0], strobes.sdiBit};
      if (strobes.instrDone) instrReg <= shiftReg[DATA_W-2:0];
    end
  end

  // Register bank, one slice per register.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        ctrlRegs[g*DATA_W +: DATA_W] <= '0;
      else if (strobes.commit && wrAddr == ADDR_W'(g))
        ctrlRegs[g*DATA_W +: DATA_W] <= shiftReg;
    end
  end

  // Read mux: unpopulated addresses read as zero.
  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (nextAddr == ADDR_W'(i)) readVal = ctrlRegs[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readShift <= '0;
      outBit    <= 1'b0;
    end else if (strobes.instrDone) begin
      readShift <= readVal;
    end else if (strobes.shiftOut) begin
      outBit    <= readShift[DATA_W-1];
      readShift <= {readShift[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdoOe,
  output logic [NUM_REGS*DATA_W-1:0] ctrlRegs
);

  strobes_t strobes;
  phase_t   phase;
  logic     isRead;
  logic     csSync;
  logic     sclkFall;

  scp_ctrl #(
    .BYTE_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclk    (sclk),
    .sdi     (sdi),
    .isRead  (isRead),
    .strobes (strobes),
    .sdoOe   (sdoOe),
    .csSync  (csSync),
    .sclkFall(sclkFall),
    .phase   (phase)
  );

  scp_datapath #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .isRead  (isRead),
    .sdo     (sdo),
    .ctrlRegs(ctrlRegs)
  );

endmodule

// File: rtl/serial_ctrl_port_chk.sv
module serial_ctrl_port_chk
  import scp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csSync,
  input logic                       sclkFall,
  input logic                       sdo,
  input logic                       sdoOe,
  input logic [NUM_REGS*DATA_W-1:0] ctrlRegs,
  input strobes_t                   strobes,
  input phase_t                     phase
);

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> !sdoOe);                                             // R6
  AST_OE_ON_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !csSync |=> sdoOe);                                             // R6
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(ctrlRegs));                         // R2
  AST_COMMIT_AT_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> csSync);                                     // R2
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !sclkFall |=> $stable(sdo));                                    // R4
  AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csSync |-> !strobes.shiftIn);                                   // R7
  AST_FULL_IGNORES_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FULL) |-> !strobes.shiftIn);                       // R8

endmodule

bind serial_ctrl_port serial_ctrl_port_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csSync  (csSync),
  .sclkFall(sclkFall),
  .sdo     (sdo),
  .sdoOe   (sdoOe),
  .ctrlRegs(ctrlRegs),
  .strobes (strobes),
  .phase   (phase)
);

// File: tb/tb_serial_ctrl_port.sv
`timescale 1ns/1ps
module tb_serial_ctrl_port;

  localparam int H = 8;  // block clocks per serial half period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        sdoOe;
  logic [63:0] ctrlRegs;
  logic [63:0] model = '0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  serial_ctrl_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .ctrlRegs(ctrlRegs)
  );

  // {read, twoPulse, addr[5:0], data[7:0], expected[7:0]}
  localparam logic [23:0] VEC [13] = '{
    {1'b0, 1'b0, 6'd0, 8'h55, 8'h00},
    {1'b0, 1'b1, 6'd3, 8'hA5, 8'h00},
    {1'b1, 1'b0, 6'd0, 8'h00, 8'h55},
    {1'b1, 1'b1, 6'd3, 8'h00, 8'hA5},
    {1'b0, 1'b0, 6'd7, 8'hFF, 8'h00},
    {1'b1, 1'b1, 6'd7, 8'h00, 8'hFF},
    {1'b0, 1'b1, 6'd1, 8'h80, 8'h00},
    {1'b1, 1'b0, 6'd1, 8'h00, 8'h80},
    {1'b0, 1'b1, 6'd2, 8'h01, 8'h00},
    {1'b1, 1'b0, 6'd2, 8'h00, 8'h01},
    {1'b1, 1'b0, 6'd5, 8'h00, 8'h00},
    {1'b0, 1'b0, 6'd0, 8'h0F, 8'h00},
    {1'b1, 1'b1, 6'd0, 8'h00, 8'h0F}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clockBit(input logic b, output logic r);
    sdi = b;
    waitClk(H);
    r = sdo;
    sclk = 1'b1;
    waitClk(H);
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      clockBit(b[i], r);
      rx[i] = r;
    end
  endtask

  task automatic release_cs();
    waitClk(H);
    csN = 1'b1;
    waitClk(4 * H);
  endtask

  task automatic xfer(input logic rd, input logic two, input logic [5:0] addr,
                      input logic [7:0] data, input int extra, input logic resv,
                      output logic [7:0] rx);
    logic [7:0] junk;
    csN = 1'b0;
    waitClk(H);
    sendByte({addr, rd, resv}, junk);
    if (two) begin
      release_cs();
      csN = 1'b0;
      waitClk(H);
    end
    sendByte(data, rx);
    for (int e = 0; e < extra; e++) begin
      logic r;
      clockBit(~data[e % 8], r);
    end
    release_cs();
  endtask

  task automatic setModel(input logic [5:0] a, input logic [7:0] d);
    if (a < 6'd8) model[a[2:0]*8 +: 8] = d;
  endtask

  initial begin
    waitClk(200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rx;
    logic [63:0] snap;
    logic        r;
    waitClk(5);
    // R1: reset state
    check(ctrlRegs == 64'h0, "R1 regs", ctrlRegs, 64'h0);
    check(sdoOe == 1'b0, "R1 oe", 64'(sdoOe), 64'h0);
    rstN = 1'b1;
    waitClk(5);

    // R6: drive enable follows select
    csN = 1'b0;
    waitClk(H);
    check(sdoOe == 1'b1, "R6 oe on", 64'(sdoOe), 64'h1);
    csN = 1'b1;
    waitClk(H);
    check(sdoOe == 1'b0, "R6 oe off", 64'(sdoOe), 64'h0);

    // Vector table: R2/R3 writes, R4/R5 reads, R11 reads keep registers
    for (int k = 0; k < 13; k++) begin
      logic [23:0] v;
      v = VEC[k];
      xfer(v[23], v[22], v[21:16], v[15:8], 0, 1'b0, rx);
      if (!v[23]) begin
        setModel(v[21:16], v[15:8]);
        check(ctrlRegs == model, v[22] ? "R3 write two-pulse" : "R2 write single",
              ctrlRegs, model);
      end else begin
        check(rx == v[7:0], v[22] ? "R5 read two-pulse" : "R4 read single",
              64'(rx), 64'(v[7:0]));
        check(ctrlRegs == model, "R11 read keeps regs", ctrlRegs, model);
      end
    end

    // R2: no commit while select still low after 16 clocks
    csN = 1'b0;
    waitClk(H);
    sendByte({6'd4, 1'b0, 1'b0}, rx);
    sendByte(8'h99, rx);
    waitClk(3 * H);
    check(ctrlRegs == model, "R2 hold before release", ctrlRegs, model);
    release_cs();
    setModel(6'd4, 8'h99);
    check(ctrlRegs == model, "R2 commit at release", ctrlRegs, model);

    // R7: partial instruction dropped, next access normal
    csN = 1'b0;
    waitClk(H);
    for (int i = 0; i < 5; i++) clockBit(1'b1, r);
    release_cs();
    xfer(1'b0, 1'b0, 6'd6, 8'h3C, 0, 1'b0, rx);
    setModel(6'd6, 8'h3C);
    check(ctrlRegs == model, "R7 after partial instr", ctrlRegs, model);

    // R7: partial second byte does not write
    csN = 1'b0;
    waitClk(H);
    sendByte({6'd6, 1'b0, 1'b0}, rx);
    for (int i = 0; i < 4; i++) clockBit(1'b0, r);
    release_cs();
    check(ctrlRegs == model, "R7 partial data no write", ctrlRegs, model);
    // and the port is back at instruction phase
    xfer(1'b1, 1'b0, 6'd6, 8'h00, 0, 1'b0, rx);
    check(rx == 8'h3C, "R7 resync read", 64'(rx), 64'h3C);

    // R8: extra clocks ignored
    xfer(1'b0, 1'b0, 6'd1, 8'hC6, 5, 1'b0, rx);
    setModel(6'd1, 8'hC6);
    check(ctrlRegs == model, "R8 extra clocks", ctrlRegs, model);

    // R9: out-of-range address
    snap = model;
    xfer(1'b0, 1'b0, 6'd40, 8'h77, 0, 1'b0, rx);
    check(ctrlRegs == snap, "R9 write ignored", ctrlRegs, snap);
    xfer(1'b1, 1'b1, 6'd40, 8'h00, 0, 1'b0, rx);
    check(rx == 8'h00, "R9 read zero", 64'(rx), 64'h0);

    // R10: reserved bit 0 set has no effect
    xfer(1'b0, 1'b1, 6'd2, 8'hC3, 0, 1'b1, rx);
    setModel(6'd2, 8'hC3);
    check(ctrlRegs == model, "R10 reserved bit write", ctrlRegs, model);
    xfer(1'b1, 1'b0, 6'd2, 8'h00, 0, 1'b1, rx);
    check(rx == 8'hC3, "R10 reserved bit read", 64'(rx), 64'hC3);
    check(sdoOe == 1'b0, "R6 oe off at end", 64'(sdoOe), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule